// File: doc/BRIEF.md
# Timer Channel Clock Control Unit

This block produces the count-enable pulses for a bank of timer channels: up to eight general timers, one operating-system timer and one watchdog. Each channel picks one of three source tick streams (peripheral, real-time and external). It divides the picked stream by a power of four and emits a single-cycle tick for every completed period. A channel runs only while its gate is open. All sources are synchronous tick enables in the one system clock domain. The timer counters that consume the ticks sit outside this block.

Software reaches the block through a simple word-addressed register bus. One address stops channels, another starts them, and a read-only status word reports which channels are stopped. Each channel also has its own control word that holds its source and prescale fields.

Each channel is a four-state machine, with the state encoding {stopped, source present}. CH_IDLE_STOP means stopped with no source. CH_IDLE_GO means running with no source. CH_HALT means stopped with a source. CH_RUN means counting. The named transitions are STOP (a stop-set write with a 1 in the channel's bit), START (a stop-clear write with a 1 in that bit), SELECT (a control write with a non-zero source field) and DESELECT (a control write with a zero source field). STOP and START toggle the stopped half of the state. SELECT and DESELECT toggle the source half. Only CH_RUN lets source ticks reach the divider.

Top module: `tmr_clk_ctrl`

## Requirements
- R1: After reset every channel is stopped, every control word reads 0 and no channel emits a tick.
- R2: Writing word address 1 stops each channel whose gate bit is 1 in the write data. Channels with 0 bits keep their state, and writes to address 0 change nothing.
- R3: Writing word address 2 starts each channel whose gate bit is 1 in the write data. Channels with 0 bits keep their state.
- R4: Reading word address 0 returns the gate state, where 1 means stopped. General timer k uses bit k, the operating-system timer uses bit 15 and the watchdog uses bit 16. All other bits read 0.
- R5: Control bits [2:0] select the source: bit 0 is the peripheral tick, bit 1 the real-time tick and bit 2 the external tick. When several bits are set, the lowest set bit wins.
- R6: Control bits [5:3] hold a prescale code n. A running channel emits one tick for every 4^n selected source ticks, one cycle after the source tick that completes the period.
- R7: Prescale codes 6 and 7 divide by 1024, the same as code 5.
- R8: A channel whose source field is 0 emits no ticks.
- R9: While a channel is stopped it emits no ticks and its divide count holds. After it restarts, counting resumes from the held value.
- R10: A control write that changes the stored value clears the divide count. A source tick in the same cycle as that write is not counted. A write of an unchanged value leaves the count alone.
- R11: The control word of channel c sits at word address 16+c. The operating-system timer is channel 8 and the watchdog is channel 9. A write replaces both fields at once, and bits above [5:0] read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pclk_tick | input | 1 | Peripheral source tick enable |
| rtc_tick | input | 1 | Real-time source tick enable |
| ext_tick | input | 1 | External source tick enable |
| chan_tick | output | 10 | Per-channel output ticks: timers 0-7, then the operating-system timer, then the watchdog |

## Verification
A control write and a source tick can land on the same clock edge of the same channel. The write takes priority: it clears the divide count and the tick is dropped. The bench provokes this by raising the peripheral tick and strobing a changed control word in one cycle. It then judges the result in two steps. First, no output tick appears in the following cycle. Second, exactly a full new period of source ticks is needed before the first output tick. A write of an unchanged value is also tried, and it must leave a partial count intact.

// File: rtl/tmr_clk_pkg.sv
package tmr_clk_pkg;

    localparam int SRC_W  = 3;
    localparam int CODE_W = 3;
    localparam int CTRL_W = SRC_W + CODE_W;

    // state encoding: {stopped, source present}
    typedef enum logic [1:0] {
        CH_IDLE_GO   = 2'b00,
        CH_RUN       = 2'b01,
        CH_IDLE_STOP = 2'b10,
        CH_HALT      = 2'b11
    } ch_state_e;

    // gate bit used by channel ch: timers first, then OS timer, then watchdog
    function automatic int gate_pos(int ch, int n_timers);
        if (ch < n_timers)       return ch;
        else if (ch == n_timers) return 15;
        else                     return 16;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int MAX_CODE = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] code,
    input  logic       clr,
    input  logic       en,
    output logic       tick
);
    localparam int CNT_W = 2 * MAX_CODE;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             tick_q;
    int               eff;

    always_comb begin
        eff   = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
        limit = CNT_W'((1 << (2 * eff)) - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (clr) begin
                cnt_q <= '0;
            end else if (en) begin
                if (cnt_q == limit) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign tick = tick_q;

    // R6
    tick_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(en));

    // R6
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt_q));

    // R10
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && !tick));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_clk_pkg::*;
#(
    parameter int MAX_CODE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_ticks,
    input  logic              stop_set,
    input  logic              stop_clr,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              stopped,
    output logic              tick
);
    ch_state_e         state_q, state_d;
    logic [CTRL_W-1:0] ctrl_r;
    logic              running;
    logic              changed;
    logic              sel_tick;
    logic              src_nx;
    logic              stop_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_r <= '0;
        else if (ctrl_we) ctrl_r <= ctrl_wdata;
    end

    assign changed = ctrl_we && (ctrl_wdata != ctrl_r);

    // lowest set source bit wins
    always_comb begin
        if (ctrl_r[0])      sel_tick = src_ticks[0];
        else if (ctrl_r[1]) sel_tick = src_ticks[1];
        else if (ctrl_r[2]) sel_tick = src_ticks[2];
        else                sel_tick = 1'b0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE_STOP;
        else        state_q <= state_d;
    end

    // next state: STOP / START / SELECT / DESELECT
    always_comb begin
        src_nx  = ctrl_we ? (|ctrl_wdata[SRC_W-1:0]) : (|ctrl_r[SRC_W-1:0]);
        stop_nx = stop_set ? 1'b1 : (stop_clr ? 1'b0 : stopped);
        unique case ({stop_nx, src_nx})
            2'b00:   state_d = CH_IDLE_GO;
            2'b01:   state_d = CH_RUN;
            2'b10:   state_d = CH_IDLE_STOP;
            default: state_d = CH_HALT;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CH_IDLE_GO:   begin stopped = 1'b0; running = 1'b0; end
            CH_RUN:       begin stopped = 1'b0; running = 1'b1; end
            CH_IDLE_STOP: begin stopped = 1'b1; running = 1'b0; end
            default:      begin stopped = 1'b1; running = 1'b0; end
        endcase
    end

    assign ctrl_q = ctrl_r;

    tmr_prescaler #(.MAX_CODE(MAX_CODE)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (ctrl_r[CTRL_W-1:SRC_W]),
        .clr   (changed),
        .en    (running && sel_tick && !changed),
        .tick  (tick)
    );

    // R2
    stop_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_set |=> stopped);

    // R3
    start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_clr && !stop_set) |=> !stopped);

    // R9
    tick_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(state_q == CH_RUN));

    // R8
    no_src_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_r[SRC_W-1:0] == '0) |-> !tick);

endmodule

// File: rtl/tmr_clk_ctrl.sv
module tmr_clk_ctrl
    import tmr_clk_pkg::*;
#(
    parameter int N_TIMERS  = 8,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 32,
    parameter int MAX_CODE  = 5,
    parameter int CTRL_BASE = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_we,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  pclk_tick,
    input  logic                  rtc_tick,
    input  logic                  ext_tick,
    output logic [N_TIMERS+1:0]   chan_tick
);
    localparam int N_CH = N_TIMERS + 2;
    localparam logic [ADDR_W-1:0] ADR_STATUS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_SET    = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_CLR    = ADDR_W'(2);

    logic [CTRL_W-1:0] ctrl_arr [N_CH];
    logic [N_CH-1:0]   stopped_v;
    logic [N_CH-1:0]   ctrl_we_v;
    logic [SRC_W-1:0]  srcs;
    logic              wr_set, wr_clr;
    logic              unused_wdata;

    assign srcs         = {ext_tick, rtc_tick, pclk_tick};
    assign wr_set       = bus_we && (bus_addr == ADR_SET);
    assign wr_clr       = bus_we && (bus_addr == ADR_CLR);
    assign unused_wdata = ^bus_wdata;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam int POS = gate_pos(c, N_TIMERS);

        assign ctrl_we_v[c] = bus_we && (bus_addr == ADDR_W'(CTRL_BASE + c));

        tmr_channel #(.MAX_CODE(MAX_CODE)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_ticks  (srcs),
            .stop_set   (wr_set && bus_wdata[POS]),
            .stop_clr   (wr_clr && bus_wdata[POS]),
            .ctrl_we    (ctrl_we_v[c]),
            .ctrl_wdata (bus_wdata[CTRL_W-1:0]),
            .ctrl_q     (ctrl_arr[c]),
            .stopped    (stopped_v[c]),
            .tick       (chan_tick[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_STATUS) begin
            for (int c = 0; c < N_CH; c++) bus_rdata[gate_pos(c, N_TIMERS)] = stopped_v[c];
        end else begin
            for (int c = 0; c < N_CH; c++)
                if (bus_addr == ADDR_W'(CTRL_BASE + c)) bus_rdata[CTRL_W-1:0] = ctrl_arr[c];
        end
    end

    // R11
    one_ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctrl_we_v));

    // R2
    status_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_STATUS) |=> $stable(stopped_v));

endmodule

// File: tb/tmr_clk_ctrl_bench.sv
module tmr_clk_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        pclk_tick = 1'b0, rtc_tick = 1'b0, ext_tick = 1'b0;
    logic [9:0]  chan_tick;

    int n_checks = 0;
    int n_fail   = 0;
    int tcount;
    bit done = 0;

    always #10 clk = ~clk;

    tmr_clk_ctrl u_tmr_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pclk_tick(pclk_tick),
        .rtc_tick(rtc_tick), .ext_tick(ext_tick), .chan_tick(chan_tick)
    );

    task automatic check(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_addr = 5'(a); bus_wdata = 32'(d); bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(string req, int a, int exp);
        @(negedge clk);
        bus_addr = 5'(a);
        #1 check(req, int'(bus_rdata), exp);
    endtask

    task automatic drive_src(int s, logic v);
        case (s)
            0: pclk_tick = v;
            1: rtc_tick  = v;
            default: ext_tick = v;
        endcase
    endtask

    // n source pulses on source s, counting ticks of channel ch into tcount
    task automatic pulses(int s, int ch, int n);
        tcount = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); drive_src(s, 1'b1);
            @(negedge clk); drive_src(s, 1'b0);
            if (chan_tick[ch]) tcount++;
        end
    endtask

    task automatic t_reset();
        rd_chk("R1", 0, 32'h180FF);
        rd_chk("R1", 16, 0);
        rd_chk("R1", 25, 0);
        wr(16, 32'h01);
        pulses(0, 0, 3);
        check("R1", tcount, 0);
        check("R1", int'(chan_tick), 0);
    endtask

    task automatic t_gate_regs();
        wr(2, 32'h1);        rd_chk("R3", 0, 32'h180FE);
        wr(2, 32'h18000);    rd_chk("R4", 0, 32'h000FE);
        wr(1, 32'h400);      rd_chk("R4", 0, 32'h000FE);
        wr(0, 32'hFFFFFFFF); rd_chk("R2", 0, 32'h000FE);
        wr(2, 32'hFF);       rd_chk("R3", 0, 0);
        wr(1, 32'h8);        rd_chk("R2", 0, 32'h8);
        wr(2, 32'h8);        rd_chk("R3", 0, 0);
    endtask

    task automatic t_source();
        wr(16, 32'h01);
        pulses(0, 0, 4); check("R5", tcount, 4);
        pulses(1, 0, 4); check("R5", tcount, 0);
        wr(18, 32'h06);
        pulses(2, 2, 3); check("R5", tcount, 0);
        pulses(1, 2, 3); check("R5", tcount, 3);
        wr(25, 32'h04);
        pulses(2, 9, 2); check("R5", tcount, 2);
    endtask

    task automatic t_prescale();
        wr(17, 32'h09);
        pulses(0, 1, 3);    check("R6", tcount, 0);
        pulses(0, 1, 1);    check("R6", tcount, 1);
        pulses(0, 1, 8);    check("R6", tcount, 2);
        wr(17, 32'h19);
        pulses(0, 1, 63);   check("R6", tcount, 0);
        pulses(0, 1, 1);    check("R6", tcount, 1);
        wr(17, 32'h29);
        pulses(0, 1, 1023); check("R6", tcount, 0);
        pulses(0, 1, 1);    check("R6", tcount, 1);
    endtask

    task automatic t_big_codes();
        wr(17, 32'h31);
        pulses(0, 1, 1023); check("R7", tcount, 0);
        pulses(0, 1, 1);    check("R7", tcount, 1);
        wr(17, 32'h39);
        pulses(0, 1, 1023); check("R7", tcount, 0);
        pulses(0, 1, 1);    check("R7", tcount, 1);
    endtask

    task automatic t_no_source();
        wr(19, 32'h08);
        pulses(0, 3, 8); check("R8", tcount, 0);
        pulses(1, 3, 8); check("R8", tcount, 0);
    endtask

    task automatic t_gate_hold();
        wr(20, 32'h09);
        pulses(0, 4, 2); check("R9", tcount, 0);
        wr(1, 32'h10);   rd_chk("R9", 0, 32'h10);
        pulses(0, 4, 6); check("R9", tcount, 0);
        wr(2, 32'h10);
        pulses(0, 4, 1); check("R9", tcount, 0);
        pulses(0, 4, 1); check("R9", tcount, 1);
    endtask

    task automatic t_ctrl_change();
        wr(21, 32'h09);
        pulses(0, 5, 3);  check("R10", tcount, 0);
        wr(21, 32'h09);
        pulses(0, 5, 1);  check("R10", tcount, 1);
        pulses(0, 5, 3);  check("R10", tcount, 0);
        wr(21, 32'h11);
        pulses(0, 5, 15); check("R10", tcount, 0);
        pulses(0, 5, 1);  check("R10", tcount, 1);
        // write and source tick in the same cycle
        wr(22, 32'h01);
        @(negedge clk);
        pclk_tick = 1'b1; bus_addr = 5'd22; bus_wdata = 32'h09; bus_we = 1'b1;
        @(negedge clk);
        pclk_tick = 1'b0; bus_we = 1'b0;
        check("R10", int'(chan_tick[6]), 0);
        pulses(0, 6, 3);  check("R10", tcount, 0);
        pulses(0, 6, 1);  check("R10", tcount, 1);
    endtask

    task automatic t_readback();
        wr(23, 32'hFFFFFFFF); rd_chk("R11", 23, 32'h3F);
        wr(24, 32'h00000012); rd_chk("R11", 24, 32'h12);
        rd_chk("R11", 25, 32'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gate_regs();
        t_source();
        t_prescale();
        t_big_codes();
        t_no_source();
        t_gate_hold();
        t_ctrl_change();
        t_readback();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule